// File: doc/BRIEF.md
# Multi-Plane NAND Block-Erase Sequencer

This controller-side block erases up to four NAND blocks in one operation, at most one block in each plane, over an 8-bit command/address bus. The host places up to four block numbers in request slots, marks the slots that are in use, and pulses `start`. The sequencer first checks the request. If no slot is in use, or two used slots fall in the same plane, it answers at once with an error and leaves the bus untouched. Otherwise it emits an erase-setup command and three row-address bytes for each used slot, followed by a single erase-confirm command for all of them.

After the confirm, the sequencer lets the device's ready line settle and then waits for it to return high. A configurable limit bounds this wait. Once the device is ready, the sequencer issues the multi-plane status command, reads one status byte, and keeps only the per-plane pass/fail bits of the planes that were requested. The result is returned with a one-cycle `done` pulse. If the device never becomes ready, `done` is raised together with a hang flag and the sequencer returns to idle.

A block number selects its plane through its low bits (plane = block mod 4). A block number together with a page index of zero forms the 17-bit row address.

Top module: `multi_plane_eraser`

## Requirements
- R1: When `start` is seen in idle with a valid request, the bus carries the following for each used slot, in ascending slot order: command byte 0x60 (`io_cle`=1), then three address bytes (`io_ale`=1). Each byte occupies one cycle with `io_wr`=1.
- R2: For block number b, the row is b*32, so the page bits are zero. Address byte k is row bits [8k+7:8k]: first {b[2:0],00000}, then b[10:3], then {0000000,b[11]}.
- R3: Exactly one confirm byte 0xD0 (`io_cle`=1) follows the last selection. Every command byte the block writes is 0x60, 0xD0 or 0x71.
- R4: The plane of block b is b[1:0]. If no slot is enabled, or two enabled slots share a plane, `done` and `req_err` are high in the cycle after `start` and no bus cycle occurs.
- R5: After the confirm, `rdy` is ignored for WB_CYCLES cycles. The block then waits for `rdy`=1, writes command 0x71, and performs one `io_rd` cycle in which it samples `io_in`.
- R6: `fail_vec[p]` equals status bit `io_in[p+1]` if plane p was requested, and 0 otherwise. `done` is a one-cycle pulse in the cycle after the read, and `fail_vec` holds its value until the next `done`.
- R7: If `rdy` stays low for TIMEOUT cycles of the wait, `done` and `hang` are raised, `fail_vec` is zero, and no status command is written.
- R8: A `start` that arrives while `busy` is high is ignored. Slot inputs are captured only when a request is accepted.
- R9: `io_cle` and `io_ale` are never both high, and `io_wr` and `io_rd` are never both high. `busy` is high from the cycle after an accepted `start` until `done`.
- R10: After reset, `busy`, `done`, `req_err`, `hang`, `io_wr`, `io_rd` and `fail_vec` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe |
| slot_en | input | 4 | Slot in use, one bit per slot |
| slot_blk | input | 48 | Block numbers, 12 bits per slot, slot 0 in the low bits |
| rdy | input | 1 | Device ready (high) / busy (low) |
| io_in | input | 8 | Status byte from the device |
| io_out | output | 8 | Command or address byte |
| io_cle | output | 1 | Current byte is a command |
| io_ale | output | 1 | Current byte is an address |
| io_wr | output | 1 | Byte write cycle |
| io_rd | output | 1 | Status read cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| req_err | output | 1 | Rejected request (with done) |
| hang | output | 1 | Ready timeout (with done) |
| fail_vec | output | 4 | Per-plane fail flags, requested planes only |

## Verification
The situation that is hardest to reach is a device that stays busy for good, because a correct device model always finishes. The bench device model has a stuck mode that holds `rdy` low, and the bench shortens TIMEOUT so that the hang path completes quickly. The masking of unused planes is the other hard case. It is reached by having the model report failures on every plane while only some planes are requested. A second `start` with different slot contents is injected halfway through an operation, to show that the captured request drives the whole byte stream.

// File: rtl/ers_pkg.sv
// Package: shared state encoding and command codes of the erase sequencer.
// Assumes an 8-bit command/address bus.
package ers_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_SETUP, S_ADDR, S_CONFIRM, S_SETTLE, S_WAIT, S_STCMD, S_STREAD
    } ers_state_t;

    localparam logic [7:0] CMD_SETUP = 8'h60;
    localparam logic [7:0] CMD_GO    = 8'hD0;
    localparam logic [7:0] CMD_STAT  = 8'h71;
endpackage

// File: rtl/plane_check.sv
// plane_check: flags a request with no used slot, or with two used slots that
// map to the same plane. Assumes the plane is the low PL_W bits of the block
// number and that NP is a power of two, at least 2.
module plane_check #(
    parameter int NP    = 4,
    parameter int BLK_W = 12
) (
    input  logic [NP-1:0]       en,
    input  logic [NP*BLK_W-1:0] blks,
    output logic                dup,
    output logic                none
);
    localparam int PL_W = $clog2(NP);

    logic [NP*NP-1:0] clash;

    // one comparator per unordered slot pair
    for (genvar i = 0; i < NP; i++) begin : g_i
        for (genvar j = 0; j < NP; j++) begin : g_j
            if (j > i) begin : g_cmp
                assign clash[i*NP+j] = en[i] && en[j] &&
                    (blks[i*BLK_W +: PL_W] == blks[j*BLK_W +: PL_W]);
            end else begin : g_nil
                assign clash[i*NP+j] = 1'b0;
            end
        end
    end

    assign dup  = |clash;
    assign none = ~|en;
endmodule

// File: rtl/slot_pick.sv
// slot_pick: returns the lowest set bit of a pending-slot mask.
// Assumes NP >= 2. When no bit is set, any is 0 and idx is 0.
module slot_pick #(
    parameter int NP = 4
) (
    input  logic [NP-1:0]         pend,
    output logic [$clog2(NP)-1:0] idx,
    output logic                  any
);
    localparam int IW = $clog2(NP);

    // scan downward so that the lowest pending slot wins
    always_comb begin
        idx = '0;
        for (int k = NP - 1; k >= 0; k--) begin
            if (pend[k]) idx = IW'(k);
        end
    end

    assign any = |pend;
endmodule

// File: rtl/wait_timer.sv
// wait_timer: cycle counter with a synchronous clear, used for the settle
// and ready-wait windows. The caller keeps the count below its wrap value.
module wait_timer #(
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    output logic [CW-1:0] cnt
);
    // count while running, restart on clear
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (run) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/multi_plane_eraser.sv
// multi_plane_eraser: erases up to NP blocks, at most one per plane. For each
// used slot it writes a setup command and the row address, then one confirm
// command. It waits for ready with a timeout and reads the per-plane status.
// Assumes: plane = block[PL_W-1:0]; status bit p+1 reports plane p; the
// device drops rdy within WB_CYCLES of the confirm; WB_CYCLES >= 1 and
// TIMEOUT >= 1.
module multi_plane_eraser
    import ers_pkg::*;
#(
    parameter int NP        = 4,
    parameter int BLK_W     = 12,
    parameter int PAGE_BITS = 5,
    parameter int WB_CYCLES = 2,
    parameter int TIMEOUT   = 100000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [NP-1:0]       slot_en,
    input  logic [NP*BLK_W-1:0] slot_blk,
    input  logic                rdy,
    input  logic [7:0]          io_in,
    output logic [7:0]          io_out,
    output logic                io_cle,
    output logic                io_ale,
    output logic                io_wr,
    output logic                io_rd,
    output logic                busy,
    output logic                done,
    output logic                req_err,
    output logic                hang,
    output logic [NP-1:0]       fail_vec
);
    localparam int PL_W   = $clog2(NP);
    localparam int ROW_W  = BLK_W + PAGE_BITS;
    localparam int N_ADDR = (ROW_W + 7) / 8;
    localparam int AC_W   = $clog2(N_ADDR + 1);
    localparam int LIM    = (TIMEOUT > WB_CYCLES) ? TIMEOUT : WB_CYCLES;
    localparam int CW     = $clog2(LIM + 1);

    ers_state_t        state;
    logic [NP-1:0]     pend;
    logic [NP-1:0]     mask_q;
    logic [PL_W-1:0]   cur_q;
    logic [AC_W-1:0]   acnt;
    logic [BLK_W-1:0]  blk_q [NP];

    logic              dup, none;
    logic [PL_W-1:0]   pick_idx;
    logic              pick_any;
    logic [NP-1:0]     req_mask;
    logic [NP-1:0]     rest;
    logic [CW-1:0]     tcnt;
    logic              settle_end, wait_end, tclr;
    logic [N_ADDR*8-1:0] row_ext;

    plane_check #(.NP(NP), .BLK_W(BLK_W)) u_check (
        .en(slot_en), .blks(slot_blk), .dup(dup), .none(none)
    );

    slot_pick #(.NP(NP)) u_pick (
        .pend(pend), .idx(pick_idx), .any(pick_any)
    );

    wait_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tclr), .run(1'b1), .cnt(tcnt)
    );

    // planes that the incoming request touches
    always_comb begin
        req_mask = '0;
        for (int i = 0; i < NP; i++) begin
            if (slot_en[i]) req_mask[slot_blk[i*BLK_W +: PL_W]] = 1'b1;
        end
    end

    // window ends and timer restart on every window boundary
    assign settle_end = (state == S_SETTLE) && (tcnt == CW'(WB_CYCLES - 1));
    assign wait_end   = (state == S_WAIT) && (tcnt == CW'(TIMEOUT - 1));
    assign tclr       = !((state == S_SETTLE) || (state == S_WAIT)) || settle_end;

    // slots still pending once the current one is finished
    assign rest    = pend & ~(NP'(1) << cur_q);
    // row address of the current slot with the page bits at zero
    assign row_ext = (N_ADDR*8)'({blk_q[cur_q], {PAGE_BITS{1'b0}}});

    // bus drive decoded from the state
    always_comb begin
        io_out = 8'h00;
        io_cle = 1'b0;
        io_ale = 1'b0;
        io_wr  = 1'b0;
        io_rd  = 1'b0;
        unique case (state)
            S_SETUP:   begin io_out = CMD_SETUP; io_cle = 1'b1; io_wr = 1'b1; end
            S_ADDR:    begin io_out = row_ext[acnt*8 +: 8]; io_ale = 1'b1; io_wr = 1'b1; end
            S_CONFIRM: begin io_out = CMD_GO; io_cle = 1'b1; io_wr = 1'b1; end
            S_STCMD:   begin io_out = CMD_STAT; io_cle = 1'b1; io_wr = 1'b1; end
            S_STREAD:  io_rd = 1'b1;
            default:   ;
        endcase
    end

    assign busy = (state != S_IDLE);

    // sequence control, request capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            pend     <= '0;
            mask_q   <= '0;
            cur_q    <= '0;
            acnt     <= '0;
            done     <= 1'b0;
            req_err  <= 1'b0;
            hang     <= 1'b0;
            fail_vec <= '0;
            for (int i = 0; i < NP; i++) blk_q[i] <= '0;
        end else begin
            done    <= 1'b0;
            req_err <= 1'b0;
            hang    <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    if (none || dup) begin
                        done     <= 1'b1;
                        req_err  <= 1'b1;
                        fail_vec <= '0;
                    end else begin
                        pend   <= slot_en;
                        mask_q <= req_mask;
                        for (int i = 0; i < NP; i++) blk_q[i] <= slot_blk[i*BLK_W +: BLK_W];
                        state  <= S_SETUP;
                    end
                end
                S_SETUP: begin
                    cur_q <= pick_idx;
                    acnt  <= '0;
                    state <= S_ADDR;
                end
                S_ADDR: begin
                    if (acnt == AC_W'(N_ADDR - 1)) begin
                        pend  <= rest;
                        state <= (rest != '0) ? S_SETUP : S_CONFIRM;
                    end else begin
                        acnt <= acnt + 1'b1;
                    end
                end
                S_CONFIRM: state <= S_SETTLE;
                S_SETTLE:  if (settle_end) state <= S_WAIT;
                S_WAIT: begin
                    if (rdy) begin
                        state <= S_STCMD;
                    end else if (wait_end) begin
                        done     <= 1'b1;
                        hang     <= 1'b1;
                        fail_vec <= '0;
                        state    <= S_IDLE;
                    end
                end
                S_STCMD: state <= S_STREAD;
                S_STREAD: begin
                    fail_vec <= io_in[NP:1] & mask_q;
                    done     <= 1'b1;
                    state    <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    logic unused_ok;
    assign unused_ok = pick_any;
endmodule

// File: rtl/ers_chk.sv
// ers_chk: property checker for multi_plane_eraser, attached by bind.
module ers_chk #(
    parameter int NP = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [7:0]    io_out,
    input logic          io_cle,
    input logic          io_ale,
    input logic          io_wr,
    input logic          io_rd,
    input logic          busy,
    input logic          done,
    input logic          req_err,
    input logic          hang,
    input logic [NP-1:0] fail_vec,
    input logic [NP-1:0] mask_q
);
    // R9
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_cle && io_ale) && !(io_wr && io_rd));
    // R3
    cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_cle) |-> (io_out == 8'h60 || io_out == 8'hD0 || io_out == 8'h71));
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    fail_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !req_err) |-> ((fail_vec & ~mask_q) == '0));
    // R4
    err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_err || hang) |-> done);
    // R4
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (!busy && $past(start)));
    // R7
    hang_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hang |-> (fail_vec == '0));
    // R9
    idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R5
    read_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd |-> $past(io_wr && io_cle && io_out == 8'h71));
endmodule

bind multi_plane_eraser ers_chk #(.NP(NP)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .io_out(io_out),
    .io_cle(io_cle), .io_ale(io_ale), .io_wr(io_wr), .io_rd(io_rd),
    .busy(busy), .done(done), .req_err(req_err), .hang(hang),
    .fail_vec(fail_vec), .mask_q(mask_q)
);

// File: tb/sim_multi_plane_eraser.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected bus bytes, the monitor pops them.
module sim_multi_plane_eraser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  slot_en = '0;
    logic [47:0] slot_blk = '0;
    logic        rdy;
    logic [7:0]  io_in;
    logic [7:0]  io_out;
    logic        io_cle, io_ale, io_wr, io_rd, busy, done, req_err, hang;
    logic [3:0]  fail_vec;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [9:0] exp_q [$];

    logic [3:0] dev_fail = '0;
    int         busy_len = 0;
    int         busy_left = 0;
    bit         stuck = 0;

    always #4 clk = ~clk;

    multi_plane_eraser #(.WB_CYCLES(2), .TIMEOUT(300)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .slot_en(slot_en),
        .slot_blk(slot_blk), .rdy(rdy), .io_in(io_in), .io_out(io_out),
        .io_cle(io_cle), .io_ale(io_ale), .io_wr(io_wr), .io_rd(io_rd),
        .busy(busy), .done(done), .req_err(req_err), .hang(hang),
        .fail_vec(fail_vec)
    );

    // device model: busy after the confirm byte, then status on read
    always @(posedge clk) begin
        if (!rst_n) busy_left <= 0;
        else if (io_wr && io_cle && io_out == 8'hD0) busy_left <= busy_len;
        else if (busy_left > 0) busy_left <= busy_left - 1;
    end
    assign rdy   = (busy_left == 0) && !stuck;
    assign io_in = io_rd ? {1'b0, rdy, 1'b0, dev_fail, |dev_fail} : 8'h00;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: every bus write must match the next expected byte (R1 R2 R3)
    always @(negedge clk) begin
        if (rst_n && io_wr) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R1: actual unexpected write %h expected none", io_out);
            end else begin
                chk("R2 bus byte", {22'd0, io_cle, io_ale, io_out}, {22'd0, exp_q.pop_front()});
            end
        end
    end

    task automatic push_sel(input logic [11:0] b);
        exp_q.push_back({2'b10, 8'h60});
        exp_q.push_back({2'b01, b[2:0], 5'b0});
        exp_q.push_back({2'b01, b[10:3]});
        exp_q.push_back({2'b01, 7'b0, b[11]});
    endtask

    task automatic run_case(input string tag, input logic [3:0] en, input logic [47:0] blks,
                            input logic [3:0] fst, input int blen, input bit stk,
                            input bit poke, input bit exp_err);
        logic [3:0] mask = '0;
        int n = 0;
        for (int i = 0; i < 4; i++) begin
            if (en[i]) mask[blks[i*12 +: 2]] = 1'b1;
        end
        if (!exp_err) begin
            for (int i = 0; i < 4; i++) if (en[i]) push_sel(blks[i*12 +: 12]);
            exp_q.push_back({2'b10, 8'hD0});
            if (!stk) exp_q.push_back({2'b10, 8'h71});
        end
        dev_fail = fst; busy_len = blen; stuck = stk;
        @(negedge clk); slot_en = en; slot_blk = blks; start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done && n < 5000) begin
            @(negedge clk); n++;
            if (poke && n == 2) begin
                start = 1'b1; slot_en = 4'b1111; slot_blk = 48'hFFF_FFF_FFF_FFF;
            end else start = 1'b0;
        end
        $display("case %s", tag);
        chk("R6 done seen", {31'd0, done}, 32'd1);
        chk("R4 req_err", {31'd0, req_err}, {31'd0, exp_err});
        chk("R7 hang", {31'd0, hang}, {31'd0, stk});
        chk("R6 fail_vec", {28'd0, fail_vec}, (exp_err || stk) ? 32'd0 : {28'd0, fst & mask});
        chk("R3 all bytes emitted", exp_q.size(), 0);
        chk("R9 idle at done", {31'd0, busy}, 32'd0);
        if (exp_err) chk("R4 immediate", n, 0);
        @(negedge clk);
        chk("R6 done one cycle", {31'd0, done}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R6 fail_vec held", {28'd0, fail_vec}, (exp_err || stk) ? 32'd0 : {28'd0, fst & mask});
        if (poke) chk("R8 no restart", {31'd0, busy}, 32'd0);
        stuck = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 reset outputs", {23'd0, busy, done, req_err, hang, io_wr, io_rd, 3'd0},
            32'd0);
        chk("R10 reset fail_vec", {28'd0, fail_vec}, 32'd0);
        // R1 R2 single block, plane 2, all status bits failing (R6 mask)
        run_case("single", 4'b0100, {12'h0, 12'hABE, 12'h0, 12'h0}, 4'b1111, 20, 0, 0, 0);
        // R1 four blocks, planes in arbitrary order, high row bit set
        run_case("four", 4'b1111, {12'h555, 12'h7FF, 12'h010, 12'h802}, 4'b1010, 50, 0, 0, 0);
        // R6 two planes requested, other planes fail but are masked
        run_case("masked", 4'b1010, {12'h0F0, 12'h0, 12'h123, 12'h0}, 4'b1111, 10, 0, 0, 0);
        // R5 device ready with no busy period
        run_case("fast", 4'b0001, {12'h0, 12'h0, 12'h0, 12'h3C9}, 4'b0010, 0, 0, 0, 0);
        // R4 duplicate plane
        run_case("dup", 4'b0011, {12'h0, 12'h0, 12'h005, 12'h001}, 4'b0000, 5, 0, 0, 1);
        // R4 no slot used
        run_case("none", 4'b0000, 48'h0, 4'b0000, 5, 0, 0, 1);
        // R7 device never ready
        run_case("hang", 4'b0001, {12'h0, 12'h0, 12'h0, 12'h004}, 4'b1111, 0, 1, 0, 0);
        // R8 second start while busy, with changed slot inputs
        run_case("poke", 4'b0110, {12'h0, 12'h0AA, 12'h0A9, 12'h0}, 4'b0110, 30, 0, 1, 0);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule